// File: doc/BRIEF.md
# Pairable Eight-Channel Pulse-Width Modulator

This block generates up to eight pulse-width modulated outputs. Each channel has its own 8-bit period register and 8-bit duty register. Any even/odd channel pair can be joined to form one 16-bit channel. Each channel counts in one of two ways. In edge mode the counter counts upward and wraps. In centre mode it counts up to the period and back down again, which gives a pulse that is symmetric about the midpoint of the period.

One shared prescaler sets the counting rate as a power-of-two fraction of the clock. Period and duty writes go into shadow registers. A channel copies them into its working registers only when it reaches its period boundary, so a waveform never changes in the middle of a period. An emergency stop input is synchronised to the clock and then latched. While the latch is set it drives every output to a programmable idle level, and it stays set until software clears it.

Configuration uses a simple write strobe with an address and a data byte. Read data is combinational from the same address.

Top module: `pwm_bank`

## Requirements
- R1: In edge mode (centre bit 0) with period P ≥ 1 and 0 < duty D < P, an enabled channel repeats every P ticks and is active for the first D ticks of each repetition.
- R2: In centre mode (centre bit 1), an enabled channel repeats every 2·P ticks and is active for 2·D ticks, centred on the turning point of the count.
- R3: Setting join bit k (register 0x03, bit k) makes pin 2k+1 carry a 16-bit channel. That channel's period is {period[2k], period[2k+1]} and its duty is {duty[2k], duty[2k+1]}. It uses the enable, centre and invert bits of channel 2k+1. Pin 2k then stays at its inactive level.
- R4: The divider field (register 0x04, bits 2:0, value n) makes one tick every 2^n clock cycles. All channels share this tick.
- R5: A duty of 0 keeps the output inactive. A duty equal to or greater than the period keeps it active for the whole period.
- R6: Invert bit c (register 0x01) makes channel c active-low. With invert 0, active means high.
- R7: Period and duty writes take effect only at the channel's period boundary. In edge mode this is the wrap. In centre mode it is the return to zero on the way down. A disabled channel copies its shadow values continuously.
- R8: When the stop function is armed (register 0x05, bit 0 = 1), a high level on `estop_in` sets the stop latch within three clock cycles. While the latch is set, every pin shows the idle level from register 0x05 bit 1. The latch state reads back as register 0x05 bit 7.
- R9: Once set, the stop latch stays set after `estop_in` falls. It clears only when software writes register 0x05 with bit 2 = 1. While the function is disarmed, `estop_in` has no effect.
- R10: When enable bit c (register 0x00) is 0, pin c sits at its inactive level, which is the value of invert bit c.
- R11: The register map is: 0x00 enable, 0x01 invert, 0x02 centre, 0x03 join, 0x04 divider, 0x05 stop control, 0x08+c period of channel c, 0x10+c duty of channel c. Every written value reads back at its address.
- R12: After reset, every register is 0 and every pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | CW (8) | Write data |
| rdata | output | CW (8) | Read data for `addr` |
| estop_in | input | 1 | Asynchronous emergency stop request |
| pwm_o | output | NCH (8) | Modulated outputs |

## Verification
The hardest behaviour to observe from the ports is the double buffering. A duty write only shows its effect if it lands after a period has started and before that period ends. To reach that window, the stimulus waits for a rising edge on the output, which marks the start of a period. It then issues the write two cycles later while counting active cycles over exactly one period, and expects the old duty. The period that follows must show the new duty. A second hard case is the stop latch holding after its input has fallen. The bench checks this by watching all pins and the read-back status bit after the request is released.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   localparam int unsigned ADDR_W = 5;

   localparam logic [ADDR_W-1:0] A_ENABLE = 5'h00;
   localparam logic [ADDR_W-1:0] A_INVERT = 5'h01;
   localparam logic [ADDR_W-1:0] A_CENTER = 5'h02;
   localparam logic [ADDR_W-1:0] A_JOIN   = 5'h03;
   localparam logic [ADDR_W-1:0] A_DIV    = 5'h04;
   localparam logic [ADDR_W-1:0] A_STOP   = 5'h05;

   // upper two address bits select the per-channel banks
   localparam logic [1:0] BANK_PER  = 2'b01;
   localparam logic [1:0] BANK_DUTY = 2'b10;

   typedef struct packed {
      logic arm;
      logic idle;
   } stop_cfg_t;

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int unsigned DIVW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DIVW-1:0] sel,
   output logic            tick
);
   localparam int unsigned PW = (1 << DIVW) - 1;

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + PW'(1);
   end

   // the low sel bits of the counter must all be one for a tick
   always_comb begin
      for (int i = 0; i < int'(PW); i++) keep[i] = (i < int'(sel));
      tick = &(cnt_q | ~keep);
   end

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NCH  = 8,
   parameter int unsigned CW   = 8,
   parameter int unsigned DIVW = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [CW-1:0]            wdata,
   input  logic                     latched,
   output logic [CW-1:0]            rdata,
   output logic [NCH-1:0]           en,
   output logic [NCH-1:0]           inv,
   output logic [NCH-1:0]           ctr,
   output logic [NCH/2-1:0]         join_q,
   output logic [DIVW-1:0]          div,
   output stop_cfg_t                stop,
   output logic                     clr,
   output logic [NCH-1:0][CW-1:0]   per_sh,
   output logic [NCH-1:0][CW-1:0]   duty_sh
);
   localparam int unsigned NPAIR = NCH / 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= '0;
         inv    <= '0;
         ctr    <= '0;
         join_q <= '0;
         div    <= '0;
         stop   <= '0;
      end else if (wr_en) begin
         case (addr)
            A_ENABLE: en     <= wdata[NCH-1:0];
            A_INVERT: inv    <= wdata[NCH-1:0];
            A_CENTER: ctr    <= wdata[NCH-1:0];
            A_JOIN:   join_q <= wdata[NPAIR-1:0];
            A_DIV:    div    <= wdata[DIVW-1:0];
            A_STOP: begin
               stop.arm  <= wdata[0];
               stop.idle <= wdata[1];
            end
            default: ;
         endcase
      end
   end

   assign clr = wr_en && (addr == A_STOP) && wdata[2];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [CW-1:0] p_q, d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= '0;
            d_q <= '0;
         end else if (wr_en) begin
            if (addr == {BANK_PER, 3'(c)})  p_q <= wdata;
            if (addr == {BANK_DUTY, 3'(c)}) d_q <= wdata;
         end
      end
      assign per_sh[c]  = p_q;
      assign duty_sh[c] = d_q;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_ENABLE: rdata[NCH-1:0]   = en;
         A_INVERT: rdata[NCH-1:0]   = inv;
         A_CENTER: rdata[NCH-1:0]   = ctr;
         A_JOIN:   rdata[NPAIR-1:0] = join_q;
         A_DIV:    rdata[DIVW-1:0]  = div;
         A_STOP: begin
            rdata[0]    = stop.arm;
            rdata[1]    = stop.idle;
            rdata[CW-1] = latched;
         end
         default: ;
      endcase
      for (int i = 0; i < int'(NCH); i++) begin
         if (addr == {BANK_PER, 3'(i)})  rdata = per_sh[i];
         if (addr == {BANK_DUTY, 3'(i)}) rdata = duty_sh[i];
      end
   end

endmodule

// File: rtl/pwm_stop.sv
module pwm_stop (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   input  logic arm,
   input  logic clr,
   output logic latched
);
   logic s1_q, s2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q    <= 1'b0;
         s2_q    <= 1'b0;
         latched <= 1'b0;
      end else begin
         s1_q    <= async_in;
         s2_q    <= s1_q;
         // a live request wins over a clear in the same cycle
         latched <= (arm && s2_q) || (latched && !clr);
      end
   end

   a_r8_sets_on_request: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && s2_q) |=> latched);

   a_r9_holds_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && !clr) |=> latched);

   a_r9_disarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && !latched) |=> !latched);

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         en,
   input  logic         center,
   input  logic         inv,
   input  logic [W-1:0] per_in,
   input  logic [W-1:0] duty_in,
   output logic         pin_q
);
   logic [W-1:0] cnt_q, cnt_d;
   logic         dn_q, dn_d;
   logic [W-1:0] per_act, duty_act;
   logic [W:0]   nxt_up;
   logic         reload;
   logic         active;

   assign nxt_up = {1'b0, cnt_q} + (W+1)'(1);

   always_comb begin
      cnt_d  = cnt_q;
      dn_d   = dn_q;
      reload = 1'b0;
      if (!en) begin
         cnt_d  = '0;
         dn_d   = 1'b0;
         reload = 1'b1;
      end else if (tick) begin
         if (!center) begin
            dn_d = 1'b0;
            if (nxt_up >= {1'b0, per_act}) begin
               cnt_d  = '0;
               reload = 1'b1;
            end else begin
               cnt_d = nxt_up[W-1:0];
            end
         end else if (!dn_q) begin
            // the top value is held for a second tick while turning
            if (nxt_up >= {1'b0, per_act}) dn_d  = 1'b1;
            else                           cnt_d = nxt_up[W-1:0];
         end else begin
            if (cnt_q == '0) begin
               dn_d   = 1'b0;
               reload = 1'b1;
            end else begin
               cnt_d = cnt_q - W'(1);
            end
         end
      end
   end

   assign active = en && (duty_act != '0) &&
                   ((duty_act >= per_act) || (cnt_q < duty_act));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         dn_q     <= 1'b0;
         per_act  <= '0;
         duty_act <= '0;
         pin_q    <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         dn_q  <= dn_d;
         if (reload) begin
            per_act  <= per_in;
            duty_act <= duty_in;
         end
         pin_q <= active ^ inv;
      end
   end

   a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (per_act != '0) |-> (cnt_q < per_act));

   a_r7_buffer_held: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> ($stable(per_act) && $stable(duty_act)));

   a_r5_zero_duty_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act == '0) |=> (pin_q == $past(inv)));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NCH  = 8,
   parameter int unsigned CW   = 8,
   parameter int unsigned DIVW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CW-1:0]     wdata,
   output logic [CW-1:0]     rdata,
   input  logic              estop_in,
   output logic [NCH-1:0]    pwm_o
);
   localparam int unsigned NPAIR = NCH / 2;
   localparam int unsigned WW    = 2 * CW;

   if (NCH < 2 || NCH > 8 || (NCH % 2) != 0) begin : g_bad_nch
      $error("pwm_bank: NCH must be even and between 2 and 8");
   end
   if (CW < NCH || CW < 3) begin : g_bad_cw
      $error("pwm_bank: CW must be at least NCH and at least 3");
   end
   if (DIVW < 1 || DIVW > 4 || DIVW > CW) begin : g_bad_divw
      $error("pwm_bank: DIVW must be between 1 and 4");
   end

   logic [NCH-1:0]         en, inv, ctr;
   logic [NPAIR-1:0]       join_q;
   logic [DIVW-1:0]        div;
   stop_cfg_t              stop;
   logic                   clr, latched, tick;
   logic [NCH-1:0][CW-1:0] per_sh, duty_sh;
   logic [NCH-1:0]         raw;

   pwm_regs #(.NCH(NCH), .CW(CW), .DIVW(DIVW)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .latched (latched),
      .rdata   (rdata),
      .en      (en),
      .inv     (inv),
      .ctr     (ctr),
      .join_q  (join_q),
      .div     (div),
      .stop    (stop),
      .clr     (clr),
      .per_sh  (per_sh),
      .duty_sh (duty_sh)
   );

   pwm_prescale #(.DIVW(DIVW)) i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (div),
      .tick  (tick)
   );

   pwm_stop i_stop (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (estop_in),
      .arm      (stop.arm),
      .clr      (clr),
      .latched  (latched)
   );

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      localparam int unsigned E = 2 * p;
      localparam int unsigned O = 2 * p + 1;

      logic [WW-1:0] per_o, duty_o;

      assign per_o  = join_q[p] ? {per_sh[E], per_sh[O]}   : {{CW{1'b0}}, per_sh[O]};
      assign duty_o = join_q[p] ? {duty_sh[E], duty_sh[O]} : {{CW{1'b0}}, duty_sh[O]};

      // the even channel is parked while its registers serve as high byte
      pwm_core #(.W(WW)) i_even (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .en      (en[E] && !join_q[p]),
         .center  (ctr[E]),
         .inv     (inv[E]),
         .per_in  ({{CW{1'b0}}, per_sh[E]}),
         .duty_in ({{CW{1'b0}}, duty_sh[E]}),
         .pin_q   (raw[E])
      );

      pwm_core #(.W(WW)) i_odd (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .en      (en[O]),
         .center  (ctr[O]),
         .inv     (inv[O]),
         .per_in  (per_o),
         .duty_in (duty_o),
         .pin_q   (raw[O])
      );
   end

   assign pwm_o = latched ? {NCH{stop.idle}} : raw;

endmodule

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;

   localparam real HALF = 2.5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       estop_in = 1'b0;
   logic [7:0] pwm_o;

   int pass_n = 0;
   int total_n = 0;

   always #(HALF) clk = ~clk;

   pwm_bank i_pwm_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .estop_in (estop_in),
      .pwm_o    (pwm_o)
   );

   typedef struct packed {
      logic        join_b;
      logic        center;
      logic [2:0]  div;
      logic [15:0] per;
      logic [15:0] duty;
      logic [15:0] exp_per;
      logic [15:0] exp_hi;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 1'b0, 3'd0, 16'd10,     16'd3,     16'd10,  16'd3},   // R1
      '{1'b0, 1'b0, 3'd2, 16'd5,      16'd2,     16'd20,  16'd8},   // R4
      '{1'b0, 1'b1, 3'd1, 16'd6,      16'd2,     16'd24,  16'd8},   // R2
      '{1'b0, 1'b1, 3'd0, 16'd9,      16'd4,     16'd18,  16'd8},   // R2
      '{1'b1, 1'b0, 3'd0, 16'h0102,   16'h0080,  16'd258, 16'd128}, // R3
      '{1'b1, 1'b1, 3'd0, 16'h0100,   16'h0041,  16'd512, 16'd130}  // R3
   };

   task automatic chk(input string req, input int act, input int exp);
      total_n++;
      if (act == exp) pass_n++;
      else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output int v);
      @(negedge clk);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   task automatic wait_rise(input int ch, output bit found);
      logic prev;
      found = 1'b0;
      @(negedge clk);
      prev = pwm_o[ch];
      for (int g = 0; g < 5000 && !found; g++) begin
         @(negedge clk);
         if (!prev && pwm_o[ch]) found = 1'b1;
         prev = pwm_o[ch];
      end
   endtask

   task automatic measure(input int ch, output int per, output int hi);
      bit found;
      bit done;
      wait_rise(ch, found);
      per = 0;
      hi = 0;
      done = 1'b0;
      if (!found) begin
         per = -1;
         hi = -1;
      end else begin
         for (int g = 0; g < 5000 && !done; g++) begin
            logic prev;
            per++;
            if (pwm_o[ch]) hi++;
            prev = pwm_o[ch];
            @(negedge clk);
            if (!prev && pwm_o[ch]) done = 1'b1;
         end
      end
   endtask

   task automatic count_high(input int ch, input int n, output int hi);
      hi = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_o[ch]) hi++;
      end
   endtask

   initial begin
      #(2.0 * HALF * 150000);
      total_n++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", pass_n, total_n);
      $finish;
   end

   initial begin
      int v, per, hi;
      string req;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      chk("R12 pins after reset", int'(pwm_o), 0);
      rd(5'h04, v);
      chk("R12 divider after reset", v, 0);
      rd(5'h0B, v);
      chk("R12 period3 after reset", v, 0);

      // R11: read-back
      wr(5'h0B, 8'hA5);
      rd(5'h0B, v);
      chk("R11 period3 readback", v, 8'hA5);
      wr(5'h17, 8'h3C);
      rd(5'h17, v);
      chk("R11 duty7 readback", v, 8'h3C);
      wr(5'h03, 8'h0A);
      rd(5'h03, v);
      chk("R11 join readback", v, 8'h0A);

      // table of waveform vectors (R1, R2, R3, R4)
      foreach (VECS[i]) begin
         vec_t vv;
         int ch;
         vv = VECS[i];
         ch = vv.join_b ? 1 : 0;
         req = vv.join_b ? "R3" : (vv.center ? "R2" : (vv.div != 0 ? "R4" : "R1"));
         wr(5'h00, 8'h00);
         wr(5'h01, 8'h00);
         wr(5'h03, {7'b0, vv.join_b});
         wr(5'h04, {5'b0, vv.div});
         wr(5'h02, vv.center ? 8'h03 : 8'h00);
         if (vv.join_b) begin
            wr(5'h08, vv.per[15:8]);
            wr(5'h09, vv.per[7:0]);
            wr(5'h10, vv.duty[15:8]);
            wr(5'h11, vv.duty[7:0]);
            wr(5'h00, 8'h02);
         end else begin
            wr(5'h08, vv.per[7:0]);
            wr(5'h10, vv.duty[7:0]);
            wr(5'h00, 8'h01);
         end
         measure(ch, per, hi);
         chk({req, " period"}, per, int'(vv.exp_per));
         chk({req, " active time"}, hi, int'(vv.exp_hi));
         if (vv.join_b) chk("R3 even pin parked", int'(pwm_o[0]), 0);
      end

      // R5: duty edge values
      wr(5'h00, 8'h00);
      wr(5'h03, 8'h00);
      wr(5'h04, 8'h00);
      wr(5'h02, 8'h00);
      wr(5'h08, 8'd10);
      wr(5'h10, 8'd0);
      wr(5'h00, 8'h01);
      count_high(0, 30, hi);
      chk("R5 duty zero inactive", hi, 0);
      wr(5'h10, 8'd10);
      repeat (12) @(negedge clk);
      count_high(0, 30, hi);
      chk("R5 duty equal period always active", hi, 30);
      wr(5'h10, 8'd200);
      repeat (12) @(negedge clk);
      count_high(0, 30, hi);
      chk("R5 duty above period always active", hi, 30);

      // R6 and R10: invert and disabled level
      wr(5'h10, 8'd3);
      wr(5'h01, 8'h05);
      measure(0, per, hi);
      chk("R6 inverted period", per, 10);
      chk("R6 inverted active-low time", hi, 7);
      chk("R10 disabled inverted pin high", int'(pwm_o[2]), 1);
      chk("R10 disabled plain pin low", int'(pwm_o[3]), 0);
      wr(5'h01, 8'h00);

      // R7: duty change lands mid-period, old value must finish the period
      wr(5'h08, 8'd20);
      wr(5'h10, 8'd4);
      repeat (25) @(negedge clk);
      begin
         bit found;
         wait_rise(0, found);
         hi = 0;
         fork
            begin
               for (int k = 0; k < 20; k++) begin
                  if (pwm_o[0]) hi++;
                  @(negedge clk);
               end
            end
            begin
               wr(5'h10, 8'd12);
            end
         join
      end
      chk("R7 current period keeps old duty", hi, 4);
      measure(0, per, hi);
      chk("R7 next period uses new duty", hi, 12);

      // R8: armed stop with idle level 1
      wr(5'h08, 8'd10);
      wr(5'h10, 8'd3);
      wr(5'h05, 8'h03);
      @(negedge clk);
      estop_in = 1'b1;
      repeat (4) @(negedge clk);
      chk("R8 all pins at idle level", int'(pwm_o), 8'hFF);
      estop_in = 1'b0;
      count_high(0, 20, hi);
      chk("R9 latch holds after release", hi, 20);
      chk("R9 all pins still forced", int'(pwm_o), 8'hFF);
      rd(5'h05, v);
      chk("R8 status bit set", (v >> 7) & 1, 1);
      wr(5'h05, 8'h07);
      rd(5'h05, v);
      chk("R9 status cleared by write", (v >> 7) & 1, 0);
      measure(0, per, hi);
      chk("R9 waveform resumes after clear", hi, 3);
      chk("R9 other pins released", int'(pwm_o[7:1]), 0);

      // R9: disarmed stop input is ignored
      wr(5'h05, 8'h02);
      @(negedge clk);
      estop_in = 1'b1;
      count_high(5, 8, hi);
      chk("R9 disarmed request has no effect", hi, 0);
      estop_in = 1'b0;
      rd(5'h05, v);
      chk("R9 disarmed status stays clear", (v >> 7) & 1, 0);
      measure(0, per, hi);
      chk("R9 disarmed waveform untouched", per, 10);

      $display("%0d/%0d checks passed", pass_n, total_n);
      $finish;
   end

endmodule